// File: doc/BRIEF.md
# Fault Event Capture Register

This block watches four external fault lines and records, for each one, a sticky event flag that is raised by a rising edge on that line. Each raw line is first brought into the CPU clock domain through a two-stage synchronizer. Software sees one status byte in which every line's synchronized level sits next to its event flag. It clears flags through a separate write-one acknowledge register.

The block sits on a plain CPU register bus with an address, a write strobe, write data and combinational read data. A single `any_event` output is high while any flag is pending, so that neighbouring logic can react to it. The block does not shut down outputs, select fault modes or raise interrupts.

Top module: `fault_capture`

## Requirements
- R1: Reading address 0 returns the status byte. Input k (k = 1..4, `flt_in[k-1]`) places its synchronized level at bit 2k-1 and its event flag at bit 2k-2, so bit 7 is the level of line 4 and bit 0 is the flag of line 1. A level change on a line is visible in the level bit two clock edges after the change.
- R2: A rising edge on a fault line sets that line's flag, and the flag is visible in the status byte after the second rising clock edge that follows the input change. It is not visible after only one edge.
- R3: A line that stays high sets its flag once only. After an acknowledge, the flag remains clear until the line falls and rises again.
- R4: A write to address 1 with bit k-1 of the data set clears flag k on that clock edge. Data bits that are 0 leave their flags unchanged, and several flags may be cleared in one write.
- R5: If a rising edge would set a flag on the same clock edge that an acknowledge clears it, the flag ends up set.
- R6: Reset clears all event flags. The level bits are not reset and always follow the synchronized inputs.
- R7: A write to the status address (0) changes no flag.
- R8: Reading address 1, or any address other than 0 and 1, returns zero.
- R9: `any_event` is high exactly when at least one event flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | CPU clock |
| rst_n | input | 1 | Active-low asynchronous reset of the event flags |
| bus_addr | input | 4 | Register address |
| bus_we | input | 1 | Write strobe, sampled on the clock edge |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Combinational read data for `bus_addr` |
| flt_in | input | 4 | Raw asynchronous fault lines, bit k-1 is line k |
| any_event | output | 1 | High while any event flag is set |

## Verification
The bench checks the flag one edge early and then on time. A design that detects the edge one stage later fails the on-time check, and one that sets the flag with no synchronizer delay fails the early check. A line held high across an acknowledge catches a design that sets flags from the level instead of the edge. An acknowledge that lands on the same edge as a new rising edge catches a design in which the clear wins. Writes of zeros, writes to the status address, partial acknowledges and reads of the acknowledge and unmapped addresses expose a design with a wrong bit layout, wrong address decode or wrong write side effects.

// File: rtl/fcap_pkg.sv
package fcap_pkg;

   // bits each fault line takes in the status byte: level above flag
   localparam int unsigned FCAP_BITS_PER_LINE = 2;

   // which register the bus currently addresses
   typedef enum logic [1:0] {
      FCAP_SEL_NONE = 2'd0,
      FCAP_SEL_STAT = 2'd1,
      FCAP_SEL_ACK  = 2'd2
   } fcap_sel_e;

   // bit position of the level of line index k (0-based)
   function automatic int unsigned fcap_lvl_pos(input int unsigned k);
      return FCAP_BITS_PER_LINE * k + 1;
   endfunction

   // bit position of the event flag of line index k (0-based)
   function automatic int unsigned fcap_flag_pos(input int unsigned k);
      return FCAP_BITS_PER_LINE * k;
   endfunction

endpackage

// File: rtl/fcap_sync.sv
// Multi-stage synchronizer for a vector of asynchronous lines.
// No reset: the level path follows the pins regardless of reset.
module fcap_sync #(
   parameter int unsigned WIDTH  = 4,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q,      // last stage
   output logic [WIDTH-1:0] q_pre   // stage before the last
);

   localparam int unsigned LAST = STAGES - 1;

   logic [WIDTH-1:0] stage_q [STAGES];

   always_ff @(posedge clk) begin
      stage_q[0] <= d;
   end

   for (genvar g = 1; g < STAGES; g++) begin : g_stage
      always_ff @(posedge clk) begin
         stage_q[g] <= stage_q[g-1];
      end
   end

   assign q     = stage_q[LAST];
   assign q_pre = stage_q[LAST-1];

endmodule

// File: rtl/fcap_chan.sv
// One fault line: edge detect and sticky event flag with set priority.
module fcap_chan (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_new,   // value that enters the last sync stage next
   input  logic lvl_cur,   // synchronized level
   input  logic ack_clr,   // write-one acknowledge for this line
   output logic rise,
   output logic flag
);

   assign rise = lvl_new & ~lvl_cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flag <= 1'b0;
      end else begin
         flag <= rise | (flag & ~ack_clr);
      end
   end

endmodule

// File: rtl/fcap_regif.sv
// Address decode, acknowledge strobes and read multiplexer.
module fcap_regif
   import fcap_pkg::*;
#(
   parameter int unsigned N_LINES   = 4,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned STAT_ADDR = 0,
   parameter int unsigned ACK_ADDR  = 1
) (
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [DATA_W-1:0]  bus_wdata,
   input  logic [N_LINES-1:0] lvl,
   input  logic [N_LINES-1:0] flag,
   output logic [N_LINES-1:0] ack_clr,
   output logic [DATA_W-1:0]  bus_rdata
);

   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] ACK_A  = ADDR_W'(ACK_ADDR);

   fcap_sel_e sel;

   always_comb begin
      if (bus_addr == STAT_A) begin
         sel = FCAP_SEL_STAT;
      end else if (bus_addr == ACK_A) begin
         sel = FCAP_SEL_ACK;
      end else begin
         sel = FCAP_SEL_NONE;
      end
   end

   // write-one clear strobes: only bits set to 1 act
   always_comb begin
      ack_clr = '0;
      if (bus_we && sel == FCAP_SEL_ACK) begin
         ack_clr = bus_wdata[N_LINES-1:0];
      end
   end

   if (DATA_W > N_LINES) begin : g_wide
      logic unused_hi_wdata;
      assign unused_hi_wdata = ^bus_wdata[DATA_W-1:N_LINES];
   end

   // status byte, interleaved level/flag; acknowledge reads as zero
   always_comb begin
      bus_rdata = '0;
      if (sel == FCAP_SEL_STAT) begin
         for (int k = 0; k < N_LINES; k++) begin
            bus_rdata[fcap_lvl_pos(k)]  = lvl[k];
            bus_rdata[fcap_flag_pos(k)] = flag[k];
         end
      end
   end

endmodule

// File: rtl/fault_capture.sv
module fault_capture
   import fcap_pkg::*;
#(
   parameter int unsigned N_LINES     = 4,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned STAT_ADDR   = 0,
   parameter int unsigned ACK_ADDR    = 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [ADDR_W-1:0]  bus_addr,
   input  logic               bus_we,
   input  logic [DATA_W-1:0]  bus_wdata,
   output logic [DATA_W-1:0]  bus_rdata,
   input  logic [N_LINES-1:0] flt_in,
   output logic               any_event
);

   localparam int unsigned STAT_BITS = FCAP_BITS_PER_LINE * N_LINES;
   localparam int unsigned ADDR_SPAN = 1 << ADDR_W;

   // elaboration-time parameter checks
   if (N_LINES < 1) begin : g_chk_lines
      $error("fault_capture: N_LINES must be at least 1");
   end
   if (DATA_W < STAT_BITS) begin : g_chk_width
      $error("fault_capture: DATA_W too narrow for the status byte");
   end
   if (SYNC_STAGES < 2) begin : g_chk_sync
      $error("fault_capture: SYNC_STAGES must be at least 2");
   end
   if (STAT_ADDR == ACK_ADDR) begin : g_chk_addr
      $error("fault_capture: status and acknowledge addresses collide");
   end
   if (STAT_ADDR >= ADDR_SPAN || ACK_ADDR >= ADDR_SPAN) begin : g_chk_span
      $error("fault_capture: register address outside ADDR_W");
   end

   logic [N_LINES-1:0] lvl_sync;
   logic [N_LINES-1:0] lvl_pre;
   logic [N_LINES-1:0] ack_clr;
   logic [N_LINES-1:0] rise_w;
   logic [N_LINES-1:0] flag_q;

   fcap_sync #(
      .WIDTH  (N_LINES),
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk   (clk),
      .d     (flt_in),
      .q     (lvl_sync),
      .q_pre (lvl_pre)
   );

   for (genvar k = 0; k < N_LINES; k++) begin : g_line
      fcap_chan u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .lvl_new (lvl_pre[k]),
         .lvl_cur (lvl_sync[k]),
         .ack_clr (ack_clr[k]),
         .rise    (rise_w[k]),
         .flag    (flag_q[k])
      );
   end

   fcap_regif #(
      .N_LINES   (N_LINES),
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .STAT_ADDR (STAT_ADDR),
      .ACK_ADDR  (ACK_ADDR)
   ) u_regif (
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .lvl       (lvl_sync),
      .flag      (flag_q),
      .ack_clr   (ack_clr),
      .bus_rdata (bus_rdata)
   );

   assign any_event = |flag_q;

endmodule

// File: rtl/fault_capture_chk.sv
module fault_capture_chk #(
   parameter int unsigned N_LINES   = 4,
   parameter int unsigned ADDR_W    = 4,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned STAT_ADDR = 0,
   parameter int unsigned ACK_ADDR  = 1
) (
   input logic               clk,
   input logic               rst_n,
   input logic [ADDR_W-1:0]  bus_addr,
   input logic               bus_we,
   input logic [DATA_W-1:0]  bus_wdata,
   input logic [DATA_W-1:0]  bus_rdata,
   input logic [N_LINES-1:0] flt_in,
   input logic               any_event,
   input logic [N_LINES-1:0] flags,
   input logic [N_LINES-1:0] rise
);

   localparam logic [ADDR_W-1:0] STAT_A = ADDR_W'(STAT_ADDR);
   localparam logic [ADDR_W-1:0] ACK_A  = ADDR_W'(ACK_ADDR);

   // cycles since reset release, saturating
   logic [2:0] up;
   logic       rst_seen;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         up <= '0;
      end else if (up != 3'd7) begin
         up <= up + 3'd1;
      end
   end

   // flags clear on the first edge after reset (R6)
   always_ff @(posedge clk) begin
      rst_seen <= rst_n;
      if (rst_n && !rst_seen) begin
         p_reset_clear_r6: assert (flags == '0)
            else $error("flags not clear after reset");
      end
   end

   logic [DATA_W-1:0] flag_bits_mask;
   always_comb begin
      flag_bits_mask = '0;
      for (int k = 0; k < N_LINES; k++) flag_bits_mask[2*k] = 1'b1;
   end

   for (genvar k = 0; k < N_LINES; k++) begin : g_line
      logic ack_hit;
      assign ack_hit = bus_we && (bus_addr == ACK_A) && bus_wdata[k];

      p_edge_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (up >= 3'd3 && $past(flt_in[k]) && !$past(flt_in[k], 2)) |=> flags[k]);

      p_no_spurious_r3: assert property (@(posedge clk) disable iff (!rst_n)
         (up >= 3'd1 && $rose(flags[k])) |-> $past(rise[k]));

      p_ack_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[k] && ack_hit && !rise[k]) |=> !flags[k]);

      p_set_wins_r5: assert property (@(posedge clk) disable iff (!rst_n)
         rise[k] |=> flags[k]);

      p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[k] && !ack_hit) |=> flags[k]);
   end

   p_ack_reads_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr != STAT_A) |-> (bus_rdata == '0));

   p_any_matches_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_addr == STAT_A) |-> (any_event == ((bus_rdata & flag_bits_mask) != '0)));

endmodule

bind fault_capture fault_capture_chk #(
   .N_LINES   (N_LINES),
   .ADDR_W    (ADDR_W),
   .DATA_W    (DATA_W),
   .STAT_ADDR (STAT_ADDR),
   .ACK_ADDR  (ACK_ADDR)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_we    (bus_we),
   .bus_wdata (bus_wdata),
   .bus_rdata (bus_rdata),
   .flt_in    (flt_in),
   .any_event (any_event),
   .flags     (flag_q),
   .rise      (rise_w)
);

// File: tb/sim_fault_capture.sv
`timescale 1ns/1ps
module sim_fault_capture;

   localparam logic [3:0] A_STAT = 4'd0;
   localparam logic [3:0] A_ACK  = 4'd1;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [3:0] bus_addr = '0;
   logic       bus_we = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic [3:0] flt_in = '0;
   logic       any_event;

   always #10 clk = ~clk;   // 50 MHz

   fault_capture u0 (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_we    (bus_we),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .flt_in    (flt_in),
      .any_event (any_event)
   );

   typedef struct {
      logic [7:0] data;
      logic       any;
      string      req;
   } exp_t;

   exp_t exp_q[$];
   event sample_ev;
   int   total = 0;
   int   bad   = 0;
   bit   done  = 1'b0;

   // monitor: pops one expected item per sample and compares
   initial begin
      forever begin
         @(sample_ev);
         if (exp_q.size() != 0) begin
            exp_t e;
            e = exp_q.pop_front();
            total++;
            if (bus_rdata !== e.data || any_event !== e.any) begin
               bad++;
               $display("FAIL %s: rdata=%h any=%b expected rdata=%h any=%b",
                        e.req, bus_rdata, any_event, e.data, e.any);
            end
         end
      end
   end

   task automatic tick(input int n);
      repeat (n) @(negedge clk);
   endtask

   // driver: selects the address, queues the expectation, fires the sample
   task automatic expect_rd(input logic [3:0] a, input logic [7:0] d,
                            input logic any, input string req);
      exp_t e;
      bus_addr = a;
      e.data = d; e.any = any; e.req = req;
      exp_q.push_back(e);
      #2;
      ->sample_ev;
      #1;
      bus_addr = A_STAT;
   endtask

   task automatic bus_write(input logic [3:0] a, input logic [7:0] d);
      bus_addr = a; bus_wdata = d; bus_we = 1'b1;
      @(negedge clk);
      bus_we = 1'b0; bus_wdata = '0; bus_addr = A_STAT;
   endtask

   initial begin
      tick(4);
      rst_n = 1'b1;
      tick(1);
      expect_rd(A_STAT, 8'h00, 1'b0, "R6 reset flags clear");

      // line 1 rises
      flt_in = 4'b0001;
      tick(1);
      expect_rd(A_STAT, 8'h00, 1'b0, "R2 not visible after one edge");
      tick(1);
      expect_rd(A_STAT, 8'h03, 1'b1, "R1/R2 level and flag of line 1");
      tick(5);
      expect_rd(A_STAT, 8'h03, 1'b1, "R7 flag sticky");
      bus_write(A_ACK, 8'h01);
      expect_rd(A_STAT, 8'h02, 1'b0, "R4 ack clears flag 1");
      tick(4);
      expect_rd(A_STAT, 8'h02, 1'b0, "R3 high level does not re-set");
      bus_write(A_STAT, 8'hFF);
      expect_rd(A_STAT, 8'h02, 1'b0, "R7 status write ignored");

      // lines 2 and 4 rise
      flt_in = 4'b1011;
      tick(2);
      expect_rd(A_STAT, 8'hCE, 1'b1, "R1 layout lines 2 and 4");
      bus_write(A_ACK, 8'h00);
      expect_rd(A_STAT, 8'hCE, 1'b1, "R4 zero ack no effect");
      bus_write(A_STAT, 8'h00);
      expect_rd(A_STAT, 8'hCE, 1'b1, "R7 status write keeps flags");
      bus_write(A_ACK, 8'h02);
      expect_rd(A_STAT, 8'hCA, 1'b1, "R4 partial ack line 2");
      bus_write(A_ACK, 8'h08);
      expect_rd(A_STAT, 8'h8A, 1'b0, "R9 any low after last ack");
      expect_rd(A_ACK, 8'h00, 1'b0, "R8 ack reads zero");
      expect_rd(4'd5, 8'h00, 1'b0, "R8 unmapped reads zero");

      // line 3: set, drop, then rise coincident with ack
      flt_in = 4'b1111;
      tick(2);
      expect_rd(A_STAT, 8'hBA, 1'b1, "R2 line 3 set");
      flt_in = 4'b1011;
      tick(3);
      expect_rd(A_STAT, 8'h9A, 1'b1, "R6 level follows, flag stays");
      flt_in = 4'b1111;
      tick(1);
      bus_write(A_ACK, 8'h04);
      expect_rd(A_STAT, 8'hBA, 1'b1, "R5 set wins over ack");
      bus_write(A_ACK, 8'h04);
      expect_rd(A_STAT, 8'hAA, 1'b0, "R4 later ack clears line 3");

      // all lines together
      flt_in = 4'b0000;
      tick(3);
      expect_rd(A_STAT, 8'h00, 1'b0, "R1 all low");
      flt_in = 4'b1111;
      tick(2);
      expect_rd(A_STAT, 8'hFF, 1'b1, "R2 all flags set");
      bus_write(A_ACK, 8'h0F);
      expect_rd(A_STAT, 8'hAA, 1'b0, "R4 multi-bit ack");

      tick(2);
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   // watchdog
   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog: run did not finish, actual=hung expected=done");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule